// File: doc/BRIEF.md
# Iterative Fixed-Point Reciprocal Unit

The block returns 1/D for an unsigned fixed-point operand D in [0.5, 1). A single multiply-add datapath computes the whole result. It evaluates a quadratic p(u) = k2·u² + k1·u + k0 in three truncating multipliers and one adder. Input multiplexers choose both the polynomial input u and the three coefficients.

In the first busy cycle, u is D and the coefficients are the fitted seed constants. This forms a starting estimate. In each later cycle, u is the fed-back estimate x and the coefficients become −D, 2 and 0. The same hardware then performs one Newton-Raphson refinement x ← 2x − D·x². A precision select, captured with the start request, chooses two refinements (about 24 correct bits) or three (full working precision). A one-cycle done pulse marks the final result.

The result port always shows the working register. While an operation runs, the intermediate estimates can therefore be observed there, starting with the seed. Exponent, sign and special-value handling belong to the surrounding logic.

Top module: `recip_nr_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `y_o` is zero.
- R2: A start request is taken only while `busy_o` is low. Starts, operand changes and precision changes during a busy operation do not alter that operation's result values or its done timing.
- R3: With `prec_i` = 0 sampled at the accepting edge, `done_o` is high for exactly one cycle, beginning three rising edges after the accepting edge (one seed cycle plus two refinements).
- R4: With `prec_i` = 1 sampled at the accepting edge, `done_o` rises four edges after the accepting edge (one seed cycle plus three refinements) and lasts one cycle.
- R5: The precision used is the value of `prec_i` at the accepting edge. Later changes of `prec_i` have no effect on the running operation.
- R6: One edge after the first busy cycle, `y_o` holds the seed x0 = a·D² + b·D + c. The defaults are a = 2.5859392, b = −5.8183020 and c = 4.2424690, each rounded to F fraction bits, and every product is truncated toward zero to F fraction bits. The seed satisfies |x0·D − 1| < 2^−6.5.
- R7: Each refinement edge loads x_next = trunc(−D·trunc(x·x)) + 2·x into `y_o`, with the same truncation toward zero.
- R8: With two refinements, the final result satisfies |y·D − 1| < 2^−24 and lies in [1.0, 2.0].
- R9: With three refinements, the final result is within 2 ulp (2·2^−F) of the exact 1/D.
- R10: The edge operands are handled. D = 0.5 with three refinements gives exactly 2.0. The largest D (all ones) meets R8 and R9.
- R11: `d_i` holds DW fraction bits (value d_i/2^DW, most significant bit set for valid operands). `y_o` holds two integer bits above F fraction bits (value y_o/2^F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin; taken only when idle |
| prec_i | input | 1 | 0: two refinements, 1: three refinements |
| d_i | input | DW | Operand D, DW fraction bits, range [0.5, 1) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: final result valid on `y_o` |
| y_o | output | F+2 | Working estimate, 2 integer bits and F fraction bits |

## Verification
The bench targets D = 0.5 and the all-ones operand, because those are where the seed error peaks. A wrong coefficient or a missing D² term would push the seed past its 2^−6.5 bound there, or fail to settle on exactly 2.0. Every intermediate estimate is compared bit for bit against an independent integer model. This catches a wrong multiplexer setting in the refinement phase, such as a nonzero constant term, a sign error on −D, or truncation toward minus infinity instead of toward zero, on the first step it occurs.

The bench also fires start requests and flips the operand and precision while the unit is busy. A design that re-accepted such a request, or that read the precision live instead of the captured copy, would move its done pulse or change its result.

// File: rtl/recip_pkg.sv
package recip_pkg;

  typedef enum logic {
    PH_SEED   = 1'b0,
    PH_REFINE = 1'b1
  } phase_e;

  // Round a real coefficient to a fixed-point integer with frac fraction bits.
  function automatic longint to_fixed(input real v, input int frac);
    return longint'(v * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/recip_mul.sv
module recip_mul #(
  parameter int W = 33,
  parameter int F = 28
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] p_o
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] BIAS = {{(PW-F){1'b0}}, {F{1'b1}}};

  // Full product, rescaled by 2^-F with truncation toward zero.
  function automatic logic signed [W-1:0] mul_trunc(input logic signed [W-1:0] a,
                                                    input logic signed [W-1:0] b);
    logic signed [PW-1:0] full;
    full = PW'(a) * PW'(b);
    if (full < 0) full = full + BIAS;
    return W'(full >>> F);
  endfunction

  assign p_o = mul_trunc(a_i, b_i);
endmodule

// File: rtl/recip_poly_dp.sv
module recip_poly_dp
  import recip_pkg::*;
#(
  parameter int     W  = 33,
  parameter int     F  = 28,
  parameter longint KA = 0,
  parameter longint KB = 0,
  parameter longint KC = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase_i,
  input  logic signed [W-1:0] d_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] p_o
);
  localparam logic signed [W-1:0] K_TWO = W'(2) <<< F;

  logic signed [W-1:0] u_sel, k2_sel, k1_sel, k0_sel;
  logic signed [W-1:0] u_sq, term2, term1;

  // Multiplexers: seed uses (D; a, b, c), refinement uses (x; -D, 2, 0).
  always_comb begin
    if (phase_i == PH_SEED) begin
      u_sel  = d_i;
      k2_sel = W'(KA);
      k1_sel = W'(KB);
      k0_sel = W'(KC);
    end else begin
      u_sel  = x_i;
      k2_sel = -d_i;
      k1_sel = K_TWO;
      k0_sel = '0;
    end
  end

  recip_mul #(.W(W), .F(F)) u_mul_sq (.a_i(u_sel),  .b_i(u_sel), .p_o(u_sq));
  recip_mul #(.W(W), .F(F)) u_mul_k2 (.a_i(k2_sel), .b_i(u_sq),  .p_o(term2));
  recip_mul #(.W(W), .F(F)) u_mul_k1 (.a_i(k1_sel), .b_i(u_sel), .p_o(term1));

  assign p_o = term2 + term1 + k0_sel;

  // R7: refinement polynomial has no constant term.
  p_refine_zero_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_REFINE && x_i == '0) |-> (p_o == '0));
endmodule

// File: rtl/recip_ctrl.sv
module recip_ctrl
  import recip_pkg::*;
#(
  parameter int NS_LO = 2,
  parameter int NS_HI = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   prec_i,
  output logic   busy_o,
  output logic   done_o,
  output logic   accept_o,
  output logic   load_o,
  output phase_e phase_o
);
  localparam int CW = $clog2(NS_HI + 1);

  logic [CW-1:0] step_q;
  logic          prec_q;
  logic          last_step;

  assign accept_o  = start_i && !busy_o;
  assign last_step = busy_o && (step_q == (prec_q ? CW'(NS_HI) : CW'(NS_LO)));
  assign load_o    = busy_o;
  assign phase_o   = (step_q == '0) ? PH_SEED : PH_REFINE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_q <= '0;
      prec_q <= 1'b0;
    end else begin
      done_o <= last_step;
      if (accept_o) begin
        busy_o <= 1'b1;
        step_q <= '0;
        prec_q <= prec_i;
      end else if (busy_o) begin
        step_q <= step_q + CW'(1);
        if (last_step) busy_o <= 1'b0;
      end
    end
  end

  // R3: done is a single-cycle pulse.
  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: done follows the step count chosen by the captured precision.
  p_done_after_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(step_q) == (prec_q ? CW'(NS_HI) : CW'(NS_LO))));

  // R2: a busy operation keeps counting regardless of start.
  p_busy_ignores_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_step) |=> (busy_o && step_q == $past(step_q) + CW'(1)));
endmodule

// File: rtl/recip_nr_unit.sv
module recip_nr_unit
  import recip_pkg::*;
#(
  parameter int  DW     = 24,
  parameter int  F      = 28,
  parameter int  NS_LO  = 2,
  parameter int  NS_HI  = 3,
  parameter real COEF_A = 2.5859392,
  parameter real COEF_B = -5.8183020,
  parameter real COEF_C = 4.2424690
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          prec_i,
  input  logic [DW-1:0] d_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [F+1:0]  y_o
);
  localparam int     W     = F + 5;
  localparam int     RW    = F + 2;
  localparam int     SH    = F - DW;
  localparam longint KA    = to_fixed(COEF_A, F);
  localparam longint KB    = to_fixed(COEF_B, F);
  localparam longint KC    = to_fixed(COEF_C, F);
  localparam logic [RW-1:0] Y_ONE = RW'(1) << F;
  localparam logic [RW-1:0] Y_TWO = RW'(1) << (F + 1);

  logic                accept, load;
  phase_e              phase;
  logic signed [W-1:0] d_q, x_q, poly;

  recip_ctrl #(.NS_LO(NS_LO), .NS_HI(NS_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i),
    .busy_o(busy_o), .done_o(done_o), .accept_o(accept), .load_o(load),
    .phase_o(phase)
  );

  recip_poly_dp #(.W(W), .F(F), .KA(KA), .KB(KB), .KC(KC)) u_dp (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .d_i(d_q), .x_i(x_q), .p_o(poly)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q <= '0;
      x_q <= '0;
    end else begin
      if (accept) d_q <= W'(d_i) << SH;
      if (load)   x_q <= poly;
    end
  end

  assign y_o = x_q[RW-1:0];

  // R6: the first cycle after acceptance is the seed cycle.
  p_seed_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && phase == PH_SEED));

  // R8: a valid operand yields a final result in [1.0, 2.0].
  p_result_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && d_q[F-1]) |-> (y_o >= Y_ONE && y_o <= Y_TWO));
endmodule

// File: tb/recip_nr_unit_tb.sv
`timescale 1ns/1ps
module recip_nr_unit_tb;
  localparam int DW = 24;
  localparam int F  = 28;
  localparam int RW = F + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          prec_i = 1'b0;
  logic [DW-1:0] d_i = '0;
  logic          busy_o, done_o;
  logic [RW-1:0] y_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  recip_nr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i), .d_i(d_i),
    .busy_o(busy_o), .done_o(done_o), .y_o(y_o)
  );

  task automatic check_int(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_real(input bit ok, input string req, input real act, input real lim);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%g expected within %g", req, act, lim);
    end
  endtask

  // Bench model: Q-format product rescaled by division (truncates toward zero).
  function automatic logic signed [127:0] qmul(input logic signed [127:0] a,
                                               input logic signed [127:0] b);
    return (a * b) / (128'sd1 <<< F);
  endfunction

  task automatic run_op(input logic [DW-1:0] d, input logic p, input bit disturb);
    logic signed [127:0] dq, ka, kb, kc, x, yv;
    logic signed [127:0] ex [0:3];
    int   nref;
    real  dr, yr, err;
    nref = p ? 3 : 2;
    dq = 128'(d) <<< (F - DW);
    ka = 128'(longint'(2.5859392 * (2.0 ** F)));
    kb = 128'(longint'(-5.8183020 * (2.0 ** F)));
    kc = 128'(longint'(4.2424690 * (2.0 ** F)));
    x = qmul(ka, qmul(dq, dq)) + qmul(kb, dq) + kc;
    ex[0] = x;
    for (int k = 1; k <= 3; k++) begin
      x = 2 * x - qmul(dq, qmul(x, x));
      ex[k] = x;
    end
    dr = real'(d) / (2.0 ** DW);

    @(negedge clk);
    start_i = 1'b1; d_i = d; prec_i = p;
    @(negedge clk);                           // after accepting edge
    start_i = 1'b0;
    check_int(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
    if (disturb) begin
      start_i = 1'b1; d_i = ~d; prec_i = ~p;  // R2: start while busy
    end
    @(negedge clk);                           // seed loaded
    start_i = 1'b0; prec_i = ~p;              // R5: precision flipped
    yv = 128'(y_o);
    check_int(yv == ex[0], "R6 seed value", longint'(yv), longint'(ex[0]));
    yr  = real'(longint'(yv)) / (2.0 ** F);
    err = yr * dr - 1.0;
    if (err < 0.0) err = -err;
    check_real(err < 2.0 ** (-6.5), "R6 seed accuracy", err, 2.0 ** (-6.5));
    check_int(done_o == 1'b0, "R3 done low in seed cycle", longint'(done_o), 0);
    for (int k = 1; k <= nref; k++) begin
      @(negedge clk);
      yv = 128'(y_o);
      check_int(yv == ex[k], "R7 refinement value", longint'(yv), longint'(ex[k]));
      if (k < nref)
        check_int(done_o == 1'b0, "R3 done early", longint'(done_o), 0);
      else if (p)
        check_int(done_o == 1'b1, "R4 done after three refinements", longint'(done_o), 1);
      else
        check_int(done_o == 1'b1, "R3 done after two refinements", longint'(done_o), 1);
    end
    yr = real'(longint'(yv)) / (2.0 ** F);
    if (p) begin
      err = yr - 1.0 / dr;
      if (err < 0.0) err = -err;
      check_real(err <= 2.0 * (2.0 ** (-F)), "R9 three-step error", err, 2.0 * (2.0 ** (-F)));
    end else begin
      err = yr * dr - 1.0;
      if (err < 0.0) err = -err;
      check_real(err < 2.0 ** (-24), "R8 two-step error", err, 2.0 ** (-24));
      check_int(yv >= (128'sd1 <<< F) && yv <= (128'sd1 <<< (F + 1)),
                "R8 result range", longint'(yv), longint'(128'sd1 <<< F));
    end
    @(negedge clk);
    check_int(done_o == 1'b0, "R3 done pulse width", longint'(done_o), 0);
    check_int(128'(y_o) == yv, "R11 result held", longint'(y_o), longint'(yv));
  endtask

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_int(busy_o == 1'b0, "R1 busy after reset", longint'(busy_o), 0);
    check_int(done_o == 1'b0, "R1 done after reset", longint'(done_o), 0);
    check_int(y_o == '0, "R1 result after reset", longint'(y_o), 0);

    // R10: D = 0.5 gives exactly 2.0 with three refinements.
    run_op(24'h800000, 1'b1, 1'b0);
    check_int(y_o == (RW'(1) << (F + 1)), "R10 half gives two", longint'(y_o),
              longint'(RW'(1) << (F + 1)));
    run_op(24'h800000, 1'b0, 1'b0);
    run_op(24'hFFFFFF, 1'b0, 1'b0);            // R10 largest D
    run_op(24'hFFFFFF, 1'b1, 1'b0);
    run_op(24'hC00000, 1'b0, 1'b1);            // R2 / R5 disturbed runs
    run_op(24'hA00000, 1'b1, 1'b1);
    run_op(24'h800001, 1'b0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      rd = {1'b1, DW'($urandom) >> 1};
      rd[DW-1] = 1'b1;
      run_op(rd, 1'($urandom), (i % 7) == 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule